// File: doc/BRIEF.md
# SPI Target Frame Decoder

This block sits on the target side of an SPI link. It turns each framed transaction from an external host into accesses on a simple parallel bus to internal registers or buffers. Every frame opens with a header and then carries a data phase. The header is a 16-bit offset followed by a control byte. The control byte names the target block, the access direction and the data-length rule. Written bytes go out as write strobes. Read bytes are fetched from the bus and shifted back to the host on MISO. The offset advances by one after every data byte, so one frame can cover a run of consecutive locations.

The SPI pins are sampled in the system clock domain through synchronizers, and the block acts on detected SCLK edges. The SCLK half period must therefore span at least six system clocks. Both clock polarities are accepted: SCLK may idle low or high, and in either case data is sampled on the rising edge and MISO changes on the falling edge. A frame has either a variable length, in which case it runs until chip select is released, or a fixed length of one, two or four data bytes. In fixed-length mode, clocks that arrive after the last byte do nothing.

Top module: `spi_frame_decoder`

## Requirements
- R1: Frames decode the same way whether SCLK idles low or idles high while chip select is asserted. MOSI is sampled on rising SCLK edges and MISO changes only on falling SCLK edges.
- R2: Every field and data byte travels most significant bit first on both MOSI and MISO.
- R3: The header is 24 bits. The first 16 bits are the start offset. The next 8 bits are the control byte: bits 7:3 select the block, bit 2 is the direction (1 = write, 0 = read), and bits 1:0 set the length rule (00 variable, 01 one byte, 10 two bytes, 11 four bytes).
- R4: In a write frame, data byte n produces exactly one single-cycle `mem_we` pulse. That pulse carries `mem_addr` = offset+n (modulo 2^16), `mem_blk` = the block field and `mem_wdata` = the byte.
- R5: In a read frame, a `mem_re` request for the offset is issued as soon as the header completes. MISO returns data byte n as the value read at offset+n. Its first bit is valid before the first data-phase rising edge. `mem_rdata` is taken one clock after `mem_re`.
- R6: In variable mode, the data phase accepts any number of bytes, one or more, until chip select rises.
- R7: In fixed mode, exactly 1, 2 or 4 bytes are transferred. Further clocks before chip select rises cause no `mem_we` or `mem_re`, and MISO stays low during them. A fixed read issues exactly as many `mem_re` requests as bytes.
- R8: If chip select rises part-way through a byte, that partial byte is discarded with no write. The next frame decodes again from its header.
- R9: While chip select is high, `mem_we`, `mem_re` and MISO are all low.
- R10: After reset, `mem_we`, `mem_re` and MISO are low.
- R11: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| mem_addr | output | 16 | Bus offset for the current access |
| mem_blk | output | 5 | Bus block select from the control byte |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 8 | Write data byte |
| mem_re | output | 1 | Single-cycle read request |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_re` |

## Verification
Two events can land on the same SCLK edge: the completion of a data byte and the end of the frame's byte budget. When the last byte of a fixed-length frame completes, one edge must both issue its final strobe and close the data phase. The bench provokes this by sending one or two bytes beyond the fixed count, in both directions. It then requires the strobe count to equal the fixed length, the addresses to stop at offset+length-1, and MISO to read as zero on the surplus bytes. A second pairing, a chip-select release in the middle of a byte, is judged by requiring that only the whole bytes before it were written.

// File: rtl/spi_fd_pkg.sv
package spi_fd_pkg;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_HOLD = 2'd2
  } phase_t;

  localparam int BYTE_W = 8;
  localparam int CTRL_W = 8;

  // Byte budget of a length code; zero means unbounded (variable).
  function automatic logic [2:0] fixed_len(input logic [1:0] code);
    case (code)
      2'b01:   fixed_len = 3'd1;
      2'b10:   fixed_len = 3'd2;
      2'b11:   fixed_len = 3'd4;
      default: fixed_len = 3'd0;
    endcase
  endfunction

  // MSB-first shift: new bit enters at the bottom.
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sr,
                                                 input logic bit_in);
    shift_in = {sr[BYTE_W-2:0], bit_in};
  endfunction

endpackage

// File: rtl/spi_fd_sync.sv
module spi_fd_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= RST_VAL;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_fd_txshift.sv
module spi_fd_txshift
  import spi_fd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              shift,
  output logic              miso
);
  logic [BYTE_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      miso  <= 1'b0;
    end else if (clear) begin
      tx_sr <= '0;
      miso  <= 1'b0;
    end else if (load) begin
      tx_sr <= load_data;
    end else if (shift) begin
      miso  <= tx_sr[BYTE_W-1];              // R2 MSB leaves first
      tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder
  import spi_fd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLK_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_blk,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam int HDR_BITS = ADDR_W + CTRL_W;
  localparam int HCNT_W   = $clog2(HDR_BITS);
  localparam logic [HCNT_W-1:0] HDR_LAST = HCNT_W'(HDR_BITS - 1);

  function automatic logic [ADDR_W-1:0] next_off(input logic [ADDR_W-1:0] a);
    next_off = a + 1'b1;                     // wraps at the top of the space
  endfunction

  // Synchronised pins: {sclk, csn, mosi}; csn resets idle-high.
  logic sclk_s, csn_s, mosi_s, sclk_d;
  spi_fd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_csn, spi_mosi}),
    .q({sclk_s, csn_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;            // tracked always, so idle level never looks like an edge
  end

  phase_t              phase;
  logic [HCNT_W-1:0]   hdr_cnt;
  logic [HDR_BITS-2:0] hdr_sr;
  logic [2:0]          bit_cnt;
  logic [BYTE_W-1:0]   rx_sr;
  logic [ADDR_W-1:0]   off;
  logic [BLK_W-1:0]    blk_q;
  logic                wr_q, var_q, rd_pend;
  logic [2:0]          left;

  // Named events for the checker.
  logic cs_idle, sclk_rise, sclk_fall, hdr_done, byte_done, in_hold, rd_active, last_byte;
  logic [HDR_BITS-1:0] hdr_word;
  logic [CTRL_W-1:0]   ctrl;
  logic [BYTE_W-1:0]   byte_word;

  assign cs_idle   = csn_s;
  assign sclk_rise = !cs_idle && sclk_s && !sclk_d;   // R1 sample edge
  assign sclk_fall = !cs_idle && !sclk_s && sclk_d;   // R1 drive edge
  assign hdr_word  = {hdr_sr, mosi_s};
  assign ctrl      = hdr_word[CTRL_W-1:0];
  assign byte_word = shift_in(rx_sr, mosi_s);
  assign hdr_done  = sclk_rise && (phase == PH_HDR) && (hdr_cnt == HDR_LAST);
  assign byte_done = sclk_rise && (phase == PH_DATA) && (bit_cnt == 3'd7);
  assign in_hold   = (phase == PH_HOLD);
  assign rd_active = (phase == PH_DATA) && !wr_q;
  assign last_byte = !var_q && (left == 3'd1);
  assign mem_blk   = blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HDR;  hdr_cnt <= '0;  hdr_sr <= '0;  bit_cnt <= '0;  rx_sr <= '0;
      off <= '0;  blk_q <= '0;  wr_q <= 1'b0;  var_q <= 1'b0;  left <= '0;
      rd_pend <= 1'b0;  mem_we <= 1'b0;  mem_re <= 1'b0;
      mem_addr <= '0;  mem_wdata <= '0;
    end else if (cs_idle) begin
      // R8/R9: release aborts any partial byte and rearms the header phase
      phase <= PH_HDR;  hdr_cnt <= '0;  bit_cnt <= '0;
      rd_pend <= 1'b0;  mem_we <= 1'b0;  mem_re <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      mem_re  <= 1'b0;
      rd_pend <= mem_re;                     // R5 read data lands one clock later
      if (sclk_rise) begin
        unique case (phase)
          PH_HDR: begin
            hdr_sr  <= hdr_word[HDR_BITS-2:0];
            hdr_cnt <= hdr_cnt + 1'b1;
            if (hdr_done) begin              // R3 header split
              phase   <= PH_DATA;
              hdr_cnt <= '0;
              bit_cnt <= '0;
              off     <= hdr_word[HDR_BITS-1:CTRL_W];
              blk_q   <= ctrl[7:3];
              wr_q    <= ctrl[2];
              var_q   <= (ctrl[1:0] == 2'b00);
              left    <= fixed_len(ctrl[1:0]);
              if (!ctrl[2]) begin            // R5 early fetch
                mem_re   <= 1'b1;
                mem_addr <= hdr_word[HDR_BITS-1:CTRL_W];
              end
            end
          end
          PH_DATA: begin
            rx_sr   <= byte_word;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
              off <= next_off(off);
              if (wr_q) begin                // R4
                mem_we    <= 1'b1;
                mem_wdata <= byte_word;
                mem_addr  <= off;
              end else begin                 // R5 prefetch, R7 none past budget
                mem_re   <= !last_byte;
                mem_addr <= next_off(off);
              end
              if (!var_q) begin              // R6 variable never leaves
                left <= left - 1'b1;
                if (last_byte) phase <= PH_HOLD;
              end
            end
          end
          default: ;                          // R7 hold: clocks ignored
        endcase
      end
    end
  end

  spi_fd_txshift u_tx (
    .clk(clk), .rst_n(rst_n),
    .clear(cs_idle || in_hold),
    .load(rd_pend),
    .load_data(mem_rdata),
    .shift(sclk_fall && rd_active),
    .miso(spi_miso)
  );
endmodule

// File: rtl/spi_frame_decoder_chk.sv
module spi_frame_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_idle,
  input logic in_hold,
  input logic wr_q,
  input logic mem_we,
  input logic mem_re,
  input logic spi_miso
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R11

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R4

  AST_WE_WRITE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_q); // R4

  AST_RE_READ_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !wr_q); // R5

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && $past(in_hold)) |-> (!mem_we && !mem_re && !spi_miso)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (!mem_we && !mem_re && !spi_miso)); // R9
endmodule

bind spi_frame_decoder spi_frame_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .in_hold(in_hold), .wr_q(wr_q),
  .mem_we(mem_we), .mem_re(mem_re), .spi_miso(spi_miso)
);

// File: tb/spi_frame_decoder_bench.sv
module spi_frame_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CLKS  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic spi_miso, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [4:0]  mem_blk;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_decoder u_spi_frame_decoder (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(spi_miso), .mem_addr(mem_addr), .mem_blk(mem_blk), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [4:0] b, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ {b, 3'b011};
  endfunction

  // Memory model and strobe log.
  int wr_cnt = 0, rd_cnt = 0;
  logic [15:0] wl_addr [256];
  logic [4:0]  wl_blk  [256];
  logic [7:0]  wl_data [256];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= pat(mem_blk, mem_addr);
    if (mem_we) begin
      wl_addr[wr_cnt[7:0]] <= mem_addr;
      wl_blk[wr_cnt[7:0]]  <= mem_blk;
      wl_data[wr_cnt[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_re) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  task automatic wait_half();
    repeat (HALF_CLKS) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic got);
    sclk = 1'b0;
    mosi = b;
    wait_half();
    got  = spi_miso;
    sclk = 1'b1;
    wait_half();
  endtask

  // Drives one frame: header, nbytes full bytes, then tail_bits extra bits.
  task automatic frame(input bit m3, input logic [15:0] off, input logic [7:0] ctrl,
                       input int nbytes, input int tail_bits);
    logic [23:0] hdr;
    logic g;
    hdr = {off, ctrl};
    @(negedge clk);
    sclk = m3;
    wait_half();
    csn = 1'b0;
    wait_half();
    for (int k = 23; k >= 0; k--) send_bit(hdr[k], g);
    for (int i = 0; i < nbytes; i++)
      for (int k = 7; k >= 0; k--) begin
        send_bit(txb[i][k], g);
        rxb[i][k] = g;
      end
    for (int k = 0; k < tail_bits; k++) send_bit(1'b1, g);
    if (!m3) sclk = 1'b0;
    wait_half();
    csn = 1'b1;
    repeat (3) wait_half();
  endtask

  // Full transaction with expectation computed from the requirements.
  task automatic run(input bit m3, input logic [15:0] off, input logic [4:0] blk,
                     input bit wr, input logic [1:0] lc, input int nbytes, input string tag);
    int w0, r0, l, nexp, rexp;
    logic [15:0] a;
    for (int i = 0; i < 16; i++) txb[i] = 8'($urandom);
    w0 = wr_cnt;
    r0 = rd_cnt;
    frame(m3, off, {blk, wr, lc}, nbytes, 0);
    l    = (lc == 2'b00) ? nbytes : (lc == 2'b01) ? 1 : (lc == 2'b10) ? 2 : 4;
    nexp = (l < nbytes) ? l : nbytes;
    if (wr) begin
      chk(wr_cnt - w0 == nexp, {tag, " R4 R7 write count"}, wr_cnt - w0, nexp);
      chk(rd_cnt == r0, {tag, " R4 no reads in write frame"}, rd_cnt - r0, 0);
      for (int i = 0; i < nexp; i++) begin
        a = off + 16'(i);
        chk(wl_addr[(w0+i) % 256] == a, {tag, " R4 R3 write address"}, wl_addr[(w0+i) % 256], a);
        chk(wl_blk[(w0+i) % 256] == blk, {tag, " R3 write block"}, wl_blk[(w0+i) % 256], blk);
        chk(wl_data[(w0+i) % 256] == txb[i], {tag, " R2 R1 write data"}, wl_data[(w0+i) % 256], txb[i]);
      end
    end else begin
      rexp = (lc != 2'b00 && nbytes >= l) ? l : nbytes + 1;
      chk(rd_cnt - r0 == rexp, {tag, " R5 R7 read request count"}, rd_cnt - r0, rexp);
      chk(wr_cnt == w0, {tag, " R5 no writes in read frame"}, wr_cnt - w0, 0);
      for (int i = 0; i < nbytes; i++) begin
        a = off + 16'(i);
        if (i < nexp)
          chk(rxb[i] == pat(blk, a), {tag, " R5 R2 R1 read byte"}, rxb[i], pat(blk, a));
        else
          chk(rxb[i] == 8'h00, {tag, " R7 MISO low past budget"}, rxb[i], 0);
      end
    end
  endtask

  initial begin
    int w0;
    logic [1:0] lc;
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    chk(!mem_we && !mem_re && !spi_miso, "R10 reset outputs low", {mem_we, mem_re, spi_miso}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mem_we && !mem_re && !spi_miso, "R9 idle outputs low", {mem_we, mem_re, spi_miso}, 0);

    // Directed corner cases.
    run(1'b0, 16'h1234, 5'd3,  1'b1, 2'b00, 5, "var write mode0 R6");
    run(1'b1, 16'h1234, 5'd3,  1'b1, 2'b00, 5, "var write mode3 R1");
    run(1'b1, 16'hFFFE, 5'd31, 1'b1, 2'b00, 4, "offset wrap R4");
    run(1'b0, 16'hFFFF, 5'd9,  1'b0, 2'b00, 3, "read wrap R5");
    run(1'b0, 16'h0040, 5'd1,  1'b1, 2'b11, 6, "fixed4 write extra R7");
    run(1'b1, 16'h0080, 5'd2,  1'b0, 2'b11, 6, "fixed4 read extra R7");
    run(1'b0, 16'h00A0, 5'd4,  1'b0, 2'b01, 3, "fixed1 read extra R7");
    run(1'b1, 16'h00C0, 5'd5,  1'b1, 2'b10, 2, "fixed2 write exact R7");
    run(1'b0, 16'h0100, 5'd6,  1'b0, 2'b00, 1, "single read R6");

    // Abort part-way through the third byte: only two writes survive.
    for (int i = 0; i < 16; i++) txb[i] = 8'($urandom);
    w0 = wr_cnt;
    frame(1'b0, 16'h0200, {5'd7, 1'b1, 2'b00}, 2, 3);
    chk(wr_cnt - w0 == 2, "R8 partial byte discarded", wr_cnt - w0, 2);
    // Abort inside the header: nothing at all.
    w0 = wr_cnt;
    frame(1'b1, 16'h0300, 8'h00, 0, 10);
    chk(wr_cnt == w0, "R8 header abort no write", wr_cnt - w0, 0);
    run(1'b1, 16'h0210, 5'd7, 1'b0, 2'b10, 2, "after abort R8");

    // Constrained random frames.
    for (int f = 0; f < 30; f++) begin
      lc = 2'($urandom);
      n  = (lc == 2'b00) ? 1 + int'($urandom % 6) : 4 + int'($urandom % 2);
      run(1'($urandom), 16'($urandom), 5'($urandom), 1'($urandom), lc, n, "random R3");
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R6 actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule